// File: doc/BRIEF.md
# Sensor Channel Readout Mode Formatter

This block builds the parallel word stream for one sync channel and a parameterised number of data channels of an image sensor's serial output link. In every word clock it sends one word per channel to the serialisers. The readout sequencer supplies per-slot timing: a valid flag for each ADC word slot, first and last markers for each line, and flags that mark the first and last line of a frame. The ADC supplies one word per data channel in each valid slot.

Two configuration bits select the content. In training mode, every channel alternates between two programmable idle words, so a receiver can find the word boundaries and correct skew between lanes. In test-image mode, the sync channel frames lines and frames as usual, but each data channel sends one fixed programmable word in place of ADC samples. This gives a stream with a known, fixed format. In normal mode, the ADC words pass through. In both framed modes, slots with no data carry the alternating idle words.

A mode change is held off while a frame is in progress, so no frame mixes two modes. All outputs are registered, with one cycle of latency.

Top module: `readout_fmt`

## Requirements
- R1: While `rst` is high, `sync_word` and every data word are zero. The first word after reset is released (and every even-numbered word after it) uses the idle A phase.
- R2: The effective mode is training when `cfg_bypass`=1 and `cfg_train_en`=1. It is test image when `cfg_bypass`=1 and `cfg_train_en`=0. It is normal when `cfg_bypass`=0.
- R3: In training mode, the sync channel and every data channel send `cfg_idle_a` and `cfg_idle_b` in alternate words, one per word clock, whatever the sequencer inputs are. The idle phase runs without a break across mode changes.
- R4: In normal mode, a valid slot drives data channel i with `adc_words[i*W +: W]`.
- R5: In test-image mode, a valid slot drives every data channel with `cfg_test_word`.
- R6: In normal and test-image modes, a slot with `seq_valid`=0 drives the sync channel and every data channel with the current idle word (A or B by phase).
- R7: In a valid slot in a framed mode, the sync word is chosen in this order. `seq_first` with `seq_sof` gives the frame-start keyword. `seq_first` alone gives the line-start keyword. `seq_last` with `seq_eof` gives the frame-end keyword. `seq_last` alone gives the line-end keyword. Any other valid slot gives the body keyword. First takes priority over last.
- R8: A frame begins at the valid slot that has both `seq_first` and `seq_sof`. It ends after the valid slot that has both `seq_last` and `seq_eof`. A configuration change made during a frame is ignored until that frame has ended.
- R9: Each output word appears on the clock edge that samples its slot's inputs, and is visible for the following cycle.
- R10: When `cfg_bypass`=0, `cfg_train_en` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_train_en | input | 1 | Training enable bit |
| cfg_bypass | input | 1 | Bypass bit (replace ADC data) |
| cfg_idle_a | input | W | Idle word for phase A |
| cfg_idle_b | input | W | Idle word for phase B |
| cfg_test_word | input | W | Fixed test-image data word |
| cfg_kw_fs | input | W | Frame-start sync keyword |
| cfg_kw_ls | input | W | Line-start sync keyword |
| cfg_kw_body | input | W | Sync keyword for mid-line data slots |
| cfg_kw_le | input | W | Line-end sync keyword |
| cfg_kw_fe | input | W | Frame-end sync keyword |
| seq_valid | input | 1 | Slot carries ADC data |
| seq_first | input | 1 | First data slot of a line |
| seq_last | input | 1 | Last data slot of a line |
| seq_sof | input | 1 | Current line is first of frame |
| seq_eof | input | 1 | Current line is last of frame |
| adc_words | input | NCH*W | ADC words, channel i at bits i*W |
| sync_word | output | W | Sync channel word |
| data_words | output | NCH*W | Data channel words, channel i at bits i*W |

## Verification
The hardest case to reach is a configuration write that lands in the middle of a frame. The bench changes the mode bits between two lines of a normal frame. It then checks that the rest of that frame still carries ADC data and normal keywords, and that test-image words appear only from the next frame-start slot onward. A second hard case is a one-slot line that is both first and last, which exercises the keyword priority. A third is a frame whose end slot coincides with a mode change; the bench drives that back to back with the next frame.

// File: rtl/rmf_pkg.sv
package rmf_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_TEST   = 2'd1,
        MODE_TRAIN  = 2'd2
    } mode_e;

    typedef struct packed {
        logic valid;
        logic first;
        logic last;
        logic sof;
        logic eof;
    } slot_t;

    function automatic mode_e decode_mode(input logic train_en, input logic bypass);
        if (!bypass)       return MODE_NORMAL;
        else if (train_en) return MODE_TRAIN;
        else               return MODE_TEST;
    endfunction

    function automatic logic slot_opens_frame(input slot_t s);
        return s.valid && s.first && s.sof;
    endfunction

    function automatic logic slot_closes_frame(input slot_t s);
        return s.valid && s.last && s.eof;
    endfunction

endpackage

// File: rtl/rmf_mode_ctrl.sv
module rmf_mode_ctrl
    import rmf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  train_en,
    input  logic  bypass,
    input  slot_t slot,
    output mode_e mode,
    output logic  frame_active
);
    mode_e cfg_mode;
    mode_e held_q;
    logic  active_q;

    assign cfg_mode     = decode_mode(train_en, bypass);
    assign mode         = active_q ? held_q : cfg_mode;
    assign frame_active = active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= MODE_NORMAL;
            active_q <= 1'b0;
        end else begin
            if (!active_q) begin
                held_q <= cfg_mode;
            end
            if (active_q) begin
                active_q <= !slot_closes_frame(slot);
            end else begin
                active_q <= slot_opens_frame(slot) && !slot_closes_frame(slot);
            end
        end
    end
endmodule

// File: rtl/rmf_idle_gen.sv
module rmf_idle_gen #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] idle_a,
    input  logic [W-1:0] idle_b,
    output logic [W-1:0] idle_word
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= ~phase_q;
    end

    assign idle_word = phase_q ? idle_b : idle_a;
endmodule

// File: rtl/rmf_data_lane.sv
module rmf_data_lane
    import rmf_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  mode_e        mode,
    input  logic         valid,
    input  logic [W-1:0] idle_word,
    input  logic [W-1:0] adc_word,
    input  logic [W-1:0] test_word,
    output logic [W-1:0] lane_word
);
    logic [W-1:0] next_word;

    always_comb begin
        next_word = idle_word;
        if (mode != MODE_TRAIN && valid) begin
            next_word = (mode == MODE_TEST) ? test_word : adc_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lane_word <= '0;
        else     lane_word <= next_word;
    end
endmodule

// File: rtl/rmf_sync_lane.sv
module rmf_sync_lane
    import rmf_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  mode_e        mode,
    input  slot_t        slot,
    input  logic [W-1:0] idle_word,
    input  logic [W-1:0] kw_fs,
    input  logic [W-1:0] kw_ls,
    input  logic [W-1:0] kw_body,
    input  logic [W-1:0] kw_le,
    input  logic [W-1:0] kw_fe,
    output logic [W-1:0] lane_word
);
    logic [W-1:0] next_word;

    always_comb begin
        next_word = idle_word;
        if (mode != MODE_TRAIN && slot.valid) begin
            if (slot.first)     next_word = slot.sof ? kw_fs : kw_ls;
            else if (slot.last) next_word = slot.eof ? kw_fe : kw_le;
            else                next_word = kw_body;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lane_word <= '0;
        else     lane_word <= next_word;
    end
endmodule

// File: rtl/readout_fmt.sv
module readout_fmt
    import rmf_pkg::*;
#(
    parameter int NCH = 4,
    parameter int W   = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_train_en,
    input  logic             cfg_bypass,
    input  logic [W-1:0]     cfg_idle_a,
    input  logic [W-1:0]     cfg_idle_b,
    input  logic [W-1:0]     cfg_test_word,
    input  logic [W-1:0]     cfg_kw_fs,
    input  logic [W-1:0]     cfg_kw_ls,
    input  logic [W-1:0]     cfg_kw_body,
    input  logic [W-1:0]     cfg_kw_le,
    input  logic [W-1:0]     cfg_kw_fe,
    input  logic             seq_valid,
    input  logic             seq_first,
    input  logic             seq_last,
    input  logic             seq_sof,
    input  logic             seq_eof,
    input  logic [NCH*W-1:0] adc_words,
    output logic [W-1:0]     sync_word,
    output logic [NCH*W-1:0] data_words
);
    localparam int BUS_W = NCH * W;

    slot_t        slot;
    mode_e        eff_mode;
    logic         frame_act;
    logic [W-1:0] idle_word;

    assign slot = '{valid: seq_valid, first: seq_first, last: seq_last,
                    sof: seq_sof, eof: seq_eof};

    rmf_mode_ctrl u_mode (
        .clk          (clk),
        .rst          (rst),
        .train_en     (cfg_train_en),
        .bypass       (cfg_bypass),
        .slot         (slot),
        .mode         (eff_mode),
        .frame_active (frame_act)
    );

    rmf_idle_gen #(.W(W)) u_idle (
        .clk       (clk),
        .rst       (rst),
        .idle_a    (cfg_idle_a),
        .idle_b    (cfg_idle_b),
        .idle_word (idle_word)
    );

    rmf_sync_lane #(.W(W)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .mode      (eff_mode),
        .slot      (slot),
        .idle_word (idle_word),
        .kw_fs     (cfg_kw_fs),
        .kw_ls     (cfg_kw_ls),
        .kw_body   (cfg_kw_body),
        .kw_le     (cfg_kw_le),
        .kw_fe     (cfg_kw_fe),
        .lane_word (sync_word)
    );

    logic [BUS_W-1:0] lanes;

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        rmf_data_lane #(.W(W)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .mode      (eff_mode),
            .valid     (seq_valid),
            .idle_word (idle_word),
            .adc_word  (adc_words[i*W +: W]),
            .test_word (cfg_test_word),
            .lane_word (lanes[i*W +: W])
        );
    end

    assign data_words = lanes;
endmodule

// File: rtl/rmf_checker.sv
module rmf_checker
    import rmf_pkg::*;
#(
    parameter int NCH = 4,
    parameter int W   = 10
) (
    input logic             clk,
    input logic             rst,
    input mode_e            eff_mode,
    input logic             frame_act,
    input logic             seq_valid,
    input logic             seq_first,
    input logic             seq_sof,
    input logic [W-1:0]     cfg_idle_a,
    input logic [W-1:0]     cfg_idle_b,
    input logic [W-1:0]     cfg_test_word,
    input logic [W-1:0]     cfg_kw_fs,
    input logic [NCH*W-1:0] adc_words,
    input logic [W-1:0]     sync_word,
    input logic [NCH*W-1:0] data_words
);
    // R1: reset clears outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (sync_word == '0 && data_words == '0));

    // R3: training mode puts the same word on every lane
    a_r3_train_uniform: assert property (@(posedge clk) disable iff (rst)
        (eff_mode == MODE_TRAIN) |=> (data_words == {NCH{sync_word}}));

    // R4: normal mode passes channel 0 ADC data
    a_r4_adc_pass: assert property (@(posedge clk) disable iff (rst)
        (eff_mode == MODE_NORMAL && seq_valid) |=> (data_words[W-1:0] == $past(adc_words[W-1:0])));

    // R5: test image mode sends the test word
    a_r5_test_word: assert property (@(posedge clk) disable iff (rst)
        (eff_mode == MODE_TEST && seq_valid) |=> (data_words[W-1:0] == $past(cfg_test_word)));

    // R6: empty slots carry an idle word
    a_r6_idle_word: assert property (@(posedge clk) disable iff (rst)
        (!seq_valid) |=> (data_words[W-1:0] == $past(cfg_idle_a) || data_words[W-1:0] == $past(cfg_idle_b)));

    // R7: frame-start slot carries the frame-start keyword
    a_r7_frame_start_kw: assert property (@(posedge clk) disable iff (rst)
        (eff_mode != MODE_TRAIN && seq_valid && seq_first && seq_sof) |=> (sync_word == $past(cfg_kw_fs)));

    // R8: mode frozen inside a frame
    a_r8_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        frame_act |-> $stable(eff_mode));
endmodule

bind readout_fmt rmf_checker #(.NCH(NCH), .W(W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .eff_mode      (eff_mode),
    .frame_act     (frame_act),
    .seq_valid     (seq_valid),
    .seq_first     (seq_first),
    .seq_sof       (seq_sof),
    .cfg_idle_a    (cfg_idle_a),
    .cfg_idle_b    (cfg_idle_b),
    .cfg_test_word (cfg_test_word),
    .cfg_kw_fs     (cfg_kw_fs),
    .adc_words     (adc_words),
    .sync_word     (sync_word),
    .data_words    (data_words)
);

// File: tb/readout_fmt_tb.sv
module readout_fmt_tb;
    localparam int NCH = 4;
    localparam int W   = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_train_en = 1'b0, cfg_bypass = 1'b0;
    logic [W-1:0] cfg_idle_a = 10'h155, cfg_idle_b = 10'h2AA, cfg_test_word = 10'h0F3;
    logic [W-1:0] cfg_kw_fs = 10'h3A1, cfg_kw_ls = 10'h3A2, cfg_kw_body = 10'h3A3;
    logic [W-1:0] cfg_kw_le = 10'h3A4, cfg_kw_fe = 10'h3A5;
    logic seq_valid = 0, seq_first = 0, seq_last = 0, seq_sof = 0, seq_eof = 0;
    logic [NCH*W-1:0] adc_words = '0;
    logic [W-1:0]     sync_word;
    logic [NCH*W-1:0] data_words;

    always #2.5 clk = ~clk;

    readout_fmt #(.NCH(NCH), .W(W)) u_dut (.*);

    int checks = 0;
    int errors = 0;

    logic [W-1:0]     q_sync[$];
    logic [NCH*W-1:0] q_data[$];
    string            q_req[$];

    // bench model state
    int     m_active = 0;
    int     m_held   = 0;   // 0 normal, 1 test, 2 train
    bit     m_phase  = 0;
    int     adc_seed = 1;
    string  scen_req = "";

    function automatic int cfg_code();
        if (!cfg_bypass) return 0;
        return cfg_train_en ? 2 : 1;
    endfunction

    task automatic drive(input bit v, input bit f, input bit l, input bit s, input bit e);
        int cm, em;
        logic [W-1:0] idle, exp_s;
        logic [NCH*W-1:0] exp_d;
        string req;
        seq_valid = v; seq_first = f; seq_last = l; seq_sof = s; seq_eof = e;
        for (int i = 0; i < NCH; i++) adc_words[i*W +: W] = W'((adc_seed * 37 + i * 113) % 1024);
        adc_seed++;
        cm = cfg_code();
        em = (m_active != 0) ? m_held : cm;
        idle = m_phase ? cfg_idle_b : cfg_idle_a;
        exp_s = idle;
        exp_d = {NCH{idle}};
        req = "R6";
        if (em == 2) req = "R3";
        else if (v) begin
            req = (em == 1) ? "R5" : "R4";
            exp_d = (em == 1) ? {NCH{cfg_test_word}} : adc_words;
            if (f)      exp_s = s ? cfg_kw_fs : cfg_kw_ls;
            else if (l) exp_s = e ? cfg_kw_fe : cfg_kw_le;
            else        exp_s = cfg_kw_body;
        end
        if (scen_req != "") req = scen_req;
        q_sync.push_back(exp_s);
        q_data.push_back(exp_d);
        q_req.push_back(req);
        if (m_active == 0) m_held = cm;
        if (m_active != 0) m_active = (v && l && e) ? 0 : 1;
        else               m_active = (v && f && s && !(l && e)) ? 1 : 0;
        m_phase = ~m_phase;
        @(negedge clk);
    endtask

    // monitor: result of slot driven before an edge is visible just after it (R9)
    always @(posedge clk) begin
        #1;
        if (!rst && q_sync.size() > 0) begin
            logic [W-1:0]     es;
            logic [NCH*W-1:0] ed;
            string            r;
            es = q_sync.pop_front();
            ed = q_data.pop_front();
            r  = q_req.pop_front();
            checks++;
            if (sync_word !== es) begin
                errors++;
                $display("FAIL %s sync actual %h expected %h", r, sync_word, es);
            end
            checks++;
            if (data_words !== ed) begin
                errors++;
                $display("FAIL %s data actual %h expected %h", r, data_words, ed);
            end
        end
    end

    task automatic send_line(input int n, input bit s, input bit e);
        for (int k = 0; k < n; k++) drive(1, k == 0, k == n - 1, s, e);
        drive(0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (sync_word !== '0 || data_words !== '0) begin
            errors++;
            $display("FAIL R1 reset actual %h/%h expected 0", sync_word, data_words);
        end
        @(negedge clk);
        rst = 1'b0;
        // R1: first words after release start at idle A phase
        scen_req = "R1";
        drive(0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
        scen_req = "";
        // R3: training overrides timing, including valid slots
        cfg_bypass = 1; cfg_train_en = 1;
        drive(0, 0, 0, 0, 0);
        send_line(3, 1, 0);
        send_line(3, 0, 1);
        // R4 / R7 normal frame of three lines
        cfg_bypass = 0; cfg_train_en = 0;
        send_line(4, 1, 0);
        send_line(5, 0, 0);
        send_line(4, 0, 1);
        // R5 / R2 test frame
        cfg_bypass = 1; cfg_train_en = 0;
        scen_req = "R2";
        send_line(4, 1, 0);
        scen_req = "";
        send_line(4, 0, 1);
        // R8: mode change mid-frame held until frame end
        cfg_bypass = 0;
        send_line(4, 1, 0);
        cfg_bypass = 1; cfg_train_en = 0;
        scen_req = "R8";
        send_line(4, 0, 0);
        send_line(4, 0, 1);
        send_line(4, 1, 0);
        // R8: training request mid-frame, then back-to-back next frame
        cfg_train_en = 1;
        send_line(3, 0, 1);
        for (int k = 0; k < 3; k++) drive(1, k == 0, k == 2, 1, 0);
        scen_req = "";
        // R10: train enable ignored with bypass low
        cfg_bypass = 0; cfg_train_en = 1;
        send_line(3, 1, 1);
        scen_req = "R10";
        send_line(4, 1, 0);
        send_line(4, 0, 1);
        // R7: one-slot line, first wins over last
        scen_req = "R7";
        send_line(1, 0, 0);
        send_line(1, 1, 1);
        send_line(2, 0, 1);
        scen_req = "R9";
        drive(0, 0, 0, 0, 0);
        scen_req = "";
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule